// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block models a synchronous cache data RAM that moves one 64-bit word per clock and reads it through a registered output stage. A host starts a four-word burst with one of two address strobes. The processor strobe always starts a read. The cache strobe starts a read or a write, depending on the byte write enables. After the start, an advance input steps the burst through the other three words of the aligned four-word block. Holding the advance input high keeps the burst on its current word, which is how wait states are inserted. A strap input picks the beat order: interleaved, where the low address bits are XORed with the beat count, or linear, where the beat count is added modulo four.

Writes are masked per byte and land on the same clock edge that presents the data. Read data comes out one clock after the edge that registered the address. The output-enable input gates the bus driver asynchronously. The bus floats after write, deselect and idle cycles. A deselect takes effect one clock late, so a read that is already in flight still finishes. The word address width is a parameter (default 9 bits). The pad driver is split into a data-out bus and a drive-enable.

Top module: `pipelined_burst_sram`

## Requirements
- R1: With chip select low and the processor strobe low, the rising edge starts a burst at the external address as a read, whatever bw_n is. The word is driven on dout during the following clock.
- R2: With chip select low, the processor strobe high and the cache strobe low, the external address starts a burst. The cycle writes if any bit of bw_n is low, and reads otherwise.
- R3: A cache strobe with chip select high deselects the block. dout_en falls one clock after that edge, so a read issued on the edge before still appears. Advance cycles after a deselect neither read nor write.
- R4: A processor strobe with chip select high is ignored. With the cache strobe high, that cycle behaves as a continue or suspend cycle of the running burst.
- R5: With both strobes high, chip select is ignored. adv_n low steps to the next beat within the same aligned four-word block, reading or writing by bw_n as in R2.
- R6: With both strobes high and adv_n high, the burst stays on its current word. Reads repeat that word, and writes go to that word.
- R7: burst_order_sel high selects interleaved order: the low two address bits of beat n are start[1:0] XOR n. After the fourth beat the burst wraps to the first word.
- R8: burst_order_sel low selects linear order: the low two bits of beat n are (start[1:0] + n) mod 4. The burst wraps after the fourth beat.
- R9: bw_n[i] low writes din[8i+7:8i] into byte lane i. A lane with bw_n[i] high keeps its old contents.
- R10: oe_n high forces dout_en low at once, with no clock involved. Lowering it again re-enables a pending read word.
- R11: After a write cycle, dout_en is low for the following clock.
- R12: Reset clears the burst state and leaves dout_en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| ads_proc_n | input | 1 | Processor address strobe, active low |
| ads_cache_n | input | 1 | Cache address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| bw_n | input | DW/8 | Active-low byte write enables, one per lane |
| burst_order_sel | input | 1 | 1 = interleaved order, 0 = linear order |
| oe_n | input | 1 | Asynchronous active-low output enable |
| addr | input | AW | External word address |
| din | input | DW | Write data |
| dout | output | DW | Registered read data |
| dout_en | output | 1 | Drive enable for the data pads |

## Verification
The bench builds the block with a 6-bit word address and the default 64-bit word. With this size, an opening series of write bursts fills every location, so every later read has a known reference value. Bursts can also start at each of the four offsets within a block, in both orders. The small array lets the scoreboard check every cycle's drive enable and data against a reference array. The scenarios include a suspended write that merges two partial byte masks into one word, and a deselect that arrives behind an in-flight read.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_START_RD,
        OP_START_WR,
        OP_DESEL,
        OP_NEXT,
        OP_HOLD
    } op_e;

    typedef struct packed {
        op_e  op;
        logic is_write;
        logic is_read;
    } cyc_ctl_t;

    // Low two address bits of a given beat within a four-word block.
    function automatic logic [1:0] beat_offset(input logic [1:0] base,
                                               input logic [1:0] beat,
                                               input logic       interleave);
        logic [1:0] sum;
        sum = base + beat;
        return interleave ? (base ^ beat) : sum;
    endfunction

endpackage

// File: rtl/bsr_decode.sv
module bsr_decode
    import burst_sram_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic             cs_n,
    input  logic             ads_proc_n,
    input  logic             ads_cache_n,
    input  logic             adv_n,
    input  logic [LANES-1:0] bw_n,
    input  logic             active,
    output cyc_ctl_t         ctl
);

    logic any_wr;
    assign any_wr = ~&bw_n;

    always_comb begin
        ctl = '{op: OP_IDLE, is_write: 1'b0, is_read: 1'b0};
        if (!cs_n && !ads_proc_n) begin
            ctl.op      = OP_START_RD;
            ctl.is_read = 1'b1;
        end else if (!cs_n && !ads_cache_n) begin
            ctl.op       = any_wr ? OP_START_WR : OP_START_RD;
            ctl.is_write = any_wr;
            ctl.is_read  = !any_wr;
        end else if (cs_n && !ads_cache_n) begin
            ctl.op = OP_DESEL;
        end else if (active) begin
            ctl.op       = adv_n ? OP_HOLD : OP_NEXT;
            ctl.is_write = any_wr;
            ctl.is_read  = !any_wr;
        end
    end

endmodule

// File: rtl/bsr_addr_gen.sv
module bsr_addr_gen
    import burst_sram_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  op_e           op,
    input  logic [AW-1:0] ext_addr,
    input  logic          interleave,
    output logic [AW-1:0] eff_addr,
    output logic          active
);

    localparam int BLK_W = AW - 2;

    logic [BLK_W-1:0] blk_q;
    logic [1:0]       base_q;
    logic [1:0]       beat_q;
    logic [1:0]       beat_nxt;
    logic             act_q;
    logic             starting;

    assign starting = (op == OP_START_RD) || (op == OP_START_WR);

    always_comb begin
        beat_nxt = (op == OP_NEXT) ? beat_q + 2'd1 : beat_q;
        if (starting) begin
            eff_addr = ext_addr;
        end else begin
            eff_addr = {blk_q, beat_offset(base_q, beat_nxt, interleave)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            blk_q  <= '0;
            base_q <= '0;
            beat_q <= '0;
        end else if (starting) begin
            act_q  <= 1'b1;
            blk_q  <= ext_addr[AW-1:2];
            base_q <= ext_addr[1:0];
            beat_q <= '0;
        end else if (op == OP_DESEL) begin
            act_q <= 1'b0;
        end else if (op == OP_NEXT) begin
            beat_q <= beat_nxt;
        end
    end

    assign active = act_q;

endmodule

// File: rtl/bsr_lane_mem.sv
module bsr_lane_mem #(
    parameter int AW    = 9,
    parameter int LANES = 8
) (
    input  logic               clk,
    input  logic               we,
    input  logic               re,
    input  logic [LANES-1:0]   bw_n,
    input  logic [AW-1:0]      addr,
    input  logic [LANES*8-1:0] wdata,
    output logic [LANES*8-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] cells [DEPTH];
        logic [7:0] rd_byte;

        always_ff @(posedge clk) begin
            if (we && !bw_n[l]) begin
                cells[addr] <= wdata[l*8 +: 8];
            end
            if (re) begin
                rd_byte <= cells[addr];
            end
        end

        assign rdata[l*8 +: 8] = rd_byte;
    end

endmodule

// File: rtl/bsr_out_stage.sv
module bsr_out_stage (
    input  logic clk,
    input  logic rst,
    input  logic rd_issue,
    input  logic oe_n,
    output logic drive
);

    logic rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= 1'b0;
        end else begin
            rd_q <= rd_issue;
        end
    end

    assign drive = rd_q & ~oe_n;

endmodule

// File: rtl/pipelined_burst_sram.sv
module pipelined_burst_sram
    import burst_sram_pkg::*;
#(
    parameter int AW = 9,
    parameter int DW = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n,
    input  logic            ads_proc_n,
    input  logic            ads_cache_n,
    input  logic            adv_n,
    input  logic [DW/8-1:0] bw_n,
    input  logic            burst_order_sel,
    input  logic            oe_n,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   din,
    output logic [DW-1:0]   dout,
    output logic            dout_en
);

    localparam int LANES = DW / 8;

    cyc_ctl_t      ctl;
    logic          active;
    logic [AW-1:0] eff_addr;

    bsr_decode #(.LANES(LANES)) u_dec (
        .cs_n        (cs_n),
        .ads_proc_n  (ads_proc_n),
        .ads_cache_n (ads_cache_n),
        .adv_n       (adv_n),
        .bw_n        (bw_n),
        .active      (active),
        .ctl         (ctl)
    );

    bsr_addr_gen #(.AW(AW)) u_agen (
        .clk        (clk),
        .rst        (rst),
        .op         (ctl.op),
        .ext_addr   (addr),
        .interleave (burst_order_sel),
        .eff_addr   (eff_addr),
        .active     (active)
    );

    bsr_lane_mem #(.AW(AW), .LANES(LANES)) u_mem (
        .clk   (clk),
        .we    (ctl.is_write),
        .re    (ctl.is_read),
        .bw_n  (bw_n),
        .addr  (eff_addr),
        .wdata (din),
        .rdata (dout)
    );

    bsr_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .rd_issue (ctl.is_read),
        .oe_n     (oe_n),
        .drive    (dout_en)
    );

endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
    parameter int AW    = 9,
    parameter int LANES = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             ads_proc_n,
    input logic             ads_cache_n,
    input logic             adv_n,
    input logic [LANES-1:0] bw_n,
    input logic             burst_order_sel,
    input logic             oe_n,
    input logic             dout_en,
    input logic             active,
    input logic [AW-1:0]    eff_addr
);

    AST_PROC_READ_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !ads_proc_n) |=> (oe_n || dout_en)); // R1

    AST_DESELECT_FLOATS: assert property (@(posedge clk) disable iff (rst)
        (cs_n && !ads_cache_n) |=> !dout_en); // R3

    AST_ADVANCE_IN_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (active && ads_proc_n && ads_cache_n && !adv_n && $stable(burst_order_sel))
        |-> (eff_addr[AW-1:2] == $past(eff_addr[AW-1:2]))
            && (eff_addr[1:0] != $past(eff_addr[1:0]))); // R5

    AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (active && ads_proc_n && ads_cache_n && adv_n && $stable(burst_order_sel))
        |-> eff_addr == $past(eff_addr)); // R6

    AST_WRITE_FLOATS: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && ads_proc_n && !ads_cache_n && !(&bw_n)) |=> !dout_en); // R11

    always_comb begin
        AST_OE_FLOATS: assert (!oe_n || !dout_en); // R10
    end

endmodule

bind pipelined_burst_sram bsr_checker #(.AW(AW), .LANES(DW/8)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cs_n            (cs_n),
    .ads_proc_n      (ads_proc_n),
    .ads_cache_n     (ads_cache_n),
    .adv_n           (adv_n),
    .bw_n            (bw_n),
    .burst_order_sel (burst_order_sel),
    .oe_n            (oe_n),
    .dout_en         (dout_en),
    .active          (active),
    .eff_addr        (eff_addr)
);

// File: tb/pipelined_burst_sram_tb.sv
module pipelined_burst_sram_tb;

    localparam int AW         = 6;
    localparam int DW         = 64;
    localparam int LN         = DW / 8;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic          cs_n, ads_proc_n, ads_cache_n, adv_n, burst_order_sel, oe_n;
    logic [LN-1:0] bw_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          dout_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    pipelined_burst_sram #(.AW(AW), .DW(DW)) u_dut (
        .clk             (clk),
        .rst             (rst),
        .cs_n            (cs_n),
        .ads_proc_n      (ads_proc_n),
        .ads_cache_n     (ads_cache_n),
        .adv_n           (adv_n),
        .bw_n            (bw_n),
        .burst_order_sel (burst_order_sel),
        .oe_n            (oe_n),
        .addr            (addr),
        .din             (din),
        .dout            (dout),
        .dout_en         (dout_en)
    );

    typedef struct {
        logic          rd;
        logic [DW-1:0] data;
        string         req;
    } exp_t;

    exp_t          sb_q[$];
    exp_t          cur;
    logic          exp_en;
    int            n_vec = 0;
    int            n_bad = 0;

    // reference state
    logic [DW-1:0]   ref_mem [1 << AW];
    bit              m_active = 0;
    logic [AW-3:0]   m_blk;
    logic [1:0]      m_base, m_beat;

    function automatic logic [DW-1:0] pat(input int k);
        return {16'hC0DE ^ k[15:0], k[15:0], ~k[15:0], 16'h5A00 + k[15:0]};
    endfunction

    task automatic drive(input logic c, input logic p, input logic a, input logic v,
                         input logic [LN-1:0] b, input logic [AW-1:0] ad,
                         input logic [DW-1:0] d, input logic oe, input logic ord,
                         input string req);
        logic [AW-1:0] eff;
        logic [1:0]    off;
        logic          anyw, rd, wr;
        exp_t          e;
        @(negedge clk);
        cs_n = c; ads_proc_n = p; ads_cache_n = a; adv_n = v;
        bw_n = b; addr = ad; din = d; oe_n = oe; burst_order_sel = ord;
        @(posedge clk);
        #1;
        anyw = ~&b; rd = 1'b0; wr = 1'b0; eff = '0;
        if ((!c && !p) || (!c && !a)) begin
            m_blk = ad[AW-1:2]; m_base = ad[1:0]; m_beat = 2'd0; m_active = 1;
            eff = ad;
            if (!c && !p) rd = 1'b1;
            else begin wr = anyw; rd = !anyw; end
        end else if (c && !a) begin
            m_active = 0;
        end else if (m_active) begin
            if (!v) m_beat = m_beat + 2'd1;
            off = ord ? (m_base ^ m_beat) : (m_base + m_beat);
            eff = {m_blk, off};
            wr = anyw; rd = !anyw;
        end
        if (wr) begin
            for (int l = 0; l < LN; l++)
                if (!b[l]) ref_mem[eff][l*8 +: 8] = d[l*8 +: 8];
        end
        e.rd   = rd;
        e.data = rd ? ref_mem[eff] : '0;
        e.req  = req;
        sb_q.push_back(e);
    endtask

    // monitor: compares the result of each driven edge during the next clock
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (sb_q.size() != 0) begin
            cur    = sb_q.pop_front();
            exp_en = cur.rd && !oe_n;
            n_vec++;
            if (dout_en !== exp_en || (exp_en && dout !== cur.data)) begin
                n_bad++;
                $display("FAIL %s: dout_en=%b dout=%h expected dout_en=%b dout=%h",
                         cur.req, dout_en, dout, exp_en, cur.data);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R12: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cs_n = 1; ads_proc_n = 1; ads_cache_n = 1; adv_n = 1;
        bw_n = '1; addr = '0; din = '0; oe_n = 0; burst_order_sel = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        n_vec++; // R12 reset state
        if (dout_en !== 1'b0) begin
            n_bad++;
            $display("FAIL R12: dout_en=%b expected 0", dout_en);
        end

        // fill every word: cache-strobe write start, then advances with cs high
        for (int blk = 0; blk < (1 << (AW-2)); blk++) begin
            drive(0, 1, 0, 1, '0, AW'(blk*4), pat(blk*4), 0, 1, "R2");
            for (int k = 1; k < 4; k++)
                drive(1, 1, 1, 0, '0, '0, pat(blk*4+k), 0, 1, "R5");
        end
        drive(1, 1, 0, 1, '1, '0, '0, 0, 1, "R3");

        // processor read with byte enables low is still a read; interleaved from offset 2
        drive(0, 0, 1, 1, '0, 6'd22, 64'hDEAD_BEEF_0000_0000, 0, 1, "R1");
        for (int k = 0; k < 4; k++) drive(1, 1, 1, 0, '1, '0, '0, 0, 1, "R7");
        // linear from offset 3 with wrap
        drive(0, 0, 1, 1, '1, 6'd39, '0, 0, 0, "R8");
        for (int k = 0; k < 4; k++) drive(1, 1, 1, 0, '1, '0, '0, 0, 0, "R8");
        // interleaved from offset 1
        drive(0, 0, 1, 1, '1, 6'd13, '0, 0, 1, "R7");
        for (int k = 0; k < 4; k++) drive(1, 1, 1, 0, '1, '0, '0, 0, 1, "R7");
        // cache-strobe read start confirms word 22 was not written
        drive(0, 1, 0, 1, '1, 6'd22, 64'hFFFF, 0, 1, "R2");

        // suspended read
        drive(0, 1, 0, 1, '1, 6'd30, '0, 0, 1, "R2");
        drive(1, 1, 1, 1, '1, '0, '0, 0, 1, "R6");
        drive(1, 1, 1, 1, '1, '0, '0, 0, 1, "R6");
        drive(1, 1, 1, 0, '1, '0, '0, 0, 1, "R6");

        // partial byte writes merged by a suspended write cycle
        drive(0, 1, 0, 1, 8'hF0, 6'd40, pat(100), 0, 1, "R9");
        drive(1, 1, 1, 1, 8'h0F, '0, pat(200), 0, 1, "R9");
        drive(0, 0, 1, 1, '1, 6'd40, '0, 0, 1, "R9");
        drive(1, 1, 1, 1, '1, '0, '0, 0, 1, "R6");

        // deselect behind an in-flight read
        drive(0, 0, 1, 1, '1, 6'd50, '0, 0, 1, "R3");
        drive(1, 1, 0, 1, '1, '0, '0, 0, 1, "R3");
        drive(1, 1, 1, 0, '0, '0, pat(999), 0, 1, "R3");
        drive(1, 1, 1, 1, '1, '0, '0, 0, 1, "R3");
        drive(0, 1, 0, 1, '1, 6'd51, '0, 0, 0, "R3");

        // processor strobe with chip select high is ignored
        drive(0, 0, 1, 1, '1, 6'd16, '0, 0, 0, "R4");
        drive(1, 0, 1, 0, '1, 6'd60, '0, 0, 0, "R4");
        drive(1, 0, 1, 1, '1, 6'd60, '0, 0, 0, "R4");
        drive(1, 0, 1, 0, '1, 6'd60, '0, 0, 0, "R4");

        // asynchronous output enable
        drive(0, 0, 1, 1, '1, 6'd33, '0, 0, 1, "R10");
        drive(1, 1, 1, 1, '1, '0, '0, 1, 1, "R10");
        drive(1, 1, 1, 1, '1, '0, '0, 0, 1, "R10");

        // write burst floats the bus, then read back
        drive(0, 1, 0, 1, '0, 6'd12, pat(300), 0, 0, "R11");
        drive(1, 1, 1, 0, '0, '0, pat(301), 0, 0, "R11");
        drive(1, 1, 1, 1, '1, '0, '0, 0, 0, "R11");
        drive(0, 0, 1, 1, '1, 6'd12, '0, 0, 0, "R11");
        drive(1, 1, 1, 0, '1, '0, '0, 0, 0, "R11");
        drive(1, 1, 0, 1, '1, '0, '0, 0, 0, "R3");
        drive(1, 1, 1, 1, '1, '0, '0, 0, 0, "R3");

        repeat (3) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule